// File: doc/BRIEF.md
# Clause-45 Style Management Target Interface

This block is the target end of a two-wire serial management bus. It oversamples the bus clock and data line in the system clock domain, frames the incoming bit stream, and checks each frame's port and device fields against configured values. It keeps a persistent 16-bit register pointer. An address frame loads the pointer. Write frames, read frames and incrementing read frames act on the stored pointer. The register file behind the block is reached through a plain strobe port with a fixed read latency.

A frame on the line is a run of ones as preamble, then a 2-bit start code, a 2-bit opcode, a 5-bit port field, a 5-bit device field, two turnaround bits and a 16-bit data field. All fields are sent most significant bit first. On reads the block takes over the line from the second turnaround bit to the last data bit. Frames in the older single-frame format carry start code 01, and the block passes over them without acting.

Top module: `mgmt_target`

## Requirements
- R1: Only start code 00 opens a frame. A frame with start code 01 causes no strobe, no line drive and no pointer change.
- R2: The start code is accepted only after at least 32 consecutive 1 bits sampled on rising bus-clock edges. A frame with a shorter preamble is ignored.
- R3: A frame whose 5-bit port field differs from `cfg_port_i`, or whose 5-bit device field differs from `cfg_dev_i`, causes no strobe, no line drive and no pointer change.
- R4: Opcode 00 stores the 16-bit data field in the pointer and raises neither `reg_wr_o` nor `reg_rd_o`.
- R5: Opcode 01 raises `reg_wr_o` for exactly one cycle after the last data bit. In that cycle `reg_addr_o` equals the pointer and `reg_wdata_o` equals the data field.
- R6: Opcode 11 raises `reg_rd_o` for one cycle with `reg_addr_o` equal to the pointer. The block drives 0 in the second turnaround bit, then drives the 16 read bits MSB first. Each bit changes after a rising bus-clock edge.
- R7: Opcode 10 reads the same way as opcode 11, then adds one to the pointer. The pointer wraps from 0xFFFF to 0x0000.
- R8: The block does not drive the line during the first turnaround bit or during non-read frames. It releases the line right after the rising edge that samples the last read data bit.
- R9: Read data is taken from `reg_rdata_i` exactly `RD_LAT` system cycles after the cycle in which `reg_rd_o` is high.
- R10: After reset the line is released, both strobes are low and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_i | input | 5 | Port field value this target answers to |
| cfg_dev_i | input | 5 | Device field value this target answers to |
| mgmt_clk_i | input | 1 | Serial bus clock from the bus master |
| mgmt_data_i | input | 1 | Serial data line as seen at the pad |
| mgmt_data_o | output | 1 | Value driven onto the data line |
| mgmt_data_oe_o | output | 1 | Data line drive enable |
| reg_addr_o | output | 16 | Register file address |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 16 | Register write data |
| reg_rd_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 16 | Register read data, valid `RD_LAT` cycles after the strobe |

## Verification
The pointer is the block's only long-lived state, so a wrong value appears at `reg_addr_o` on the next read or write strobe. It also appears in the returned word one frame later. That frame is at most about 70 bus-clock periods after the corrupting frame. A frame decoder that is out of step appears at once as a missing or extra strobe, or as the line being driven in the wrong bit slot. The bench checks these at every turnaround and data slot. A wrong read-latency alignment returns a filler word instead of the register contents within the same frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RDINC = 2'b10,
    OP_READ  = 2'b11
  } mgmt_op_e;

  typedef enum logic [2:0] {
    RX_HUNT,
    RX_START,
    RX_HDR,
    RX_TA,
    RX_DATA
  } rx_state_e;

  typedef struct packed {
    logic hdr_ok;     // header matched this target
    logic ta_first;   // first turnaround bit sampled
    logic ta_last;    // second turnaround bit sampled
    logic data_bit;   // a data bit sampled
    logic data_last;  // final data bit sampled
  } rx_evt_t;

endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mgmt_frame_rx.sv
module mgmt_frame_rx
  import mgmt_pkg::*;
#(
  parameter int PRE_MIN = 32,
  parameter int FIELD_W = 5,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_val,
  input  logic [FIELD_W-1:0] cfg_port,
  input  logic [FIELD_W-1:0] cfg_dev,
  output rx_evt_t            evt,
  output mgmt_op_e           op,
  output logic [DATA_W-1:0]  word
);

  localparam int HDR_BITS = 2 + 2 * FIELD_W;
  localparam int TA_BITS  = 2;
  localparam int PRE_W    = $clog2(PRE_MIN + 1);
  localparam int CNT_MAX  = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W    = $clog2(CNT_MAX);
  localparam logic [PRE_W-1:0] PRE_FULL  = PRE_W'(PRE_MIN);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] TA_LAST   = CNT_W'(TA_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  rx_state_e           state_q, state_d;
  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [HDR_BITS-2:0] hdr_q, hdr_d;
  logic [DATA_W-2:0]   wsh_q, wsh_d;
  mgmt_op_e            op_q, op_d;

  logic [HDR_BITS-1:0] hdr_full;
  mgmt_op_e            hdr_op;
  logic [FIELD_W-1:0]  hdr_port, hdr_dev;
  logic                hdr_match;

  assign hdr_full  = {hdr_q, bit_val};
  assign hdr_op    = mgmt_op_e'(hdr_full[HDR_BITS-1 -: 2]);
  assign hdr_port  = hdr_full[2*FIELD_W-1 -: FIELD_W];
  assign hdr_dev   = hdr_full[FIELD_W-1:0];
  assign hdr_match = (hdr_port == cfg_port) && (hdr_dev == cfg_dev);
  assign word      = {wsh_q, bit_val};

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    wsh_d   = wsh_q;
    op_d    = op_q;
    evt     = '0;
    if (bit_en) begin
      unique case (state_q)
        RX_HUNT: begin
          if (bit_val) begin
            if (pre_q != PRE_FULL) pre_d = pre_q + 1'b1;
          end else begin
            pre_d = '0;
            if (pre_q == PRE_FULL) state_d = RX_START;
          end
        end
        RX_START: begin
          if (bit_val) begin
            state_d = RX_HUNT;  // older single-frame format: pass over it
          end else begin
            state_d = RX_HDR;
            cnt_d   = '0;
          end
        end
        RX_HDR: begin
          hdr_d = hdr_full[HDR_BITS-2:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == HDR_LAST) begin
            cnt_d = '0;
            if (hdr_match) begin
              state_d    = RX_TA;
              op_d       = hdr_op;
              evt.hdr_ok = 1'b1;
            end else begin
              state_d = RX_HUNT;
            end
          end
        end
        RX_TA: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == TA_LAST) begin
            evt.ta_last = 1'b1;
            state_d     = RX_DATA;
            cnt_d       = '0;
          end else begin
            evt.ta_first = 1'b1;
          end
        end
        RX_DATA: begin
          wsh_d        = word[DATA_W-2:0];
          evt.data_bit = 1'b1;
          cnt_d        = cnt_q + 1'b1;
          if (cnt_q == DATA_LAST) begin
            evt.data_last = 1'b1;
            state_d       = RX_HUNT;
            cnt_d         = '0;
          end
        end
        default: state_d = RX_HUNT;
      endcase
    end
  end

  assign op = op_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      pre_q   <= '0;
      cnt_q   <= '0;
      hdr_q   <= '0;
      wsh_q   <= '0;
      op_q    <= OP_ADDR;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      wsh_q   <= wsh_d;
      op_q    <= op_d;
    end
  end

  // R2: a zero seen before the preamble count is full keeps the hunt going
  assert_short_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && state_q == RX_HUNT && !bit_val && pre_q != PRE_FULL)
      |=> (state_q == RX_HUNT && pre_q == '0));

  // R1: a second start bit of 1 sends the decoder back to hunting
  assert_start01_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && state_q == RX_START && bit_val) |=> (state_q == RX_HUNT));

endmodule

// File: rtl/mgmt_addr_ptr.sv
module mgmt_addr_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr_q + 1'b1;  // natural wrap at the top
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/mgmt_tx.sv
module mgmt_tx #(
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              ta_first,
  input  logic              ta_last,
  input  logic              data_bit,
  input  logic              data_last,
  output logic              drv_o,
  output logic              drv_oe
);

  logic [RD_LAT-1:0] lat_q, lat_d;
  logic              capture;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              act_q, act_d;
  logic              oe_q, oe_d;
  logic              out_q, out_d;

  if (RD_LAT == 1) begin : g_lat1
    assign lat_d = rd_issue;
  end else begin : g_latn
    assign lat_d = {lat_q[RD_LAT-2:0], rd_issue};
  end
  assign capture = lat_q[RD_LAT-1];

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    oe_d  = oe_q;
    out_d = out_q;
    if (capture) sh_d = rd_data;
    if (start) act_d = 1'b1;
    if (act_q) begin
      if (ta_first) begin
        oe_d  = 1'b1;
        out_d = 1'b0;
      end
      if (ta_last || (data_bit && !data_last)) begin
        out_d = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      end
      if (data_last) begin
        oe_d  = 1'b0;
        out_d = 1'b0;
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      sh_q  <= sh_d;
      act_q <= act_d;
      oe_q  <= oe_d;
      out_q <= out_d;
    end
  end

  assign drv_o  = out_q;
  assign drv_oe = oe_q;

  // R8: the line is let go right after the last data bit is sampled
  assert_release_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_last |=> !drv_oe);

  // R6: the first driven value is the turnaround zero
  assert_ta_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !out_q);

endmodule

// File: rtl/mgmt_target.sv
module mgmt_target
  import mgmt_pkg::*;
#(
  parameter int FIELD_W     = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_MIN     = 32,
  parameter int RD_LAT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] cfg_port_i,
  input  logic [FIELD_W-1:0] cfg_dev_i,
  input  logic               mgmt_clk_i,
  input  logic               mgmt_data_i,
  output logic               mgmt_data_o,
  output logic               mgmt_data_oe_o,
  output logic [DATA_W-1:0]  reg_addr_o,
  output logic               reg_wr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_rd_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);

  localparam int ADDR_W = DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  assign rst_sync_n = rst_s_q;

  // bus clock and data into the system domain
  logic [1:0] sync_q;
  logic       sclk, sdat, sclk_prev_q, bit_en;

  mgmt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    ({mgmt_clk_i, mgmt_data_i}),
    .q    (sync_q)
  );
  assign sclk = sync_q[1];
  assign sdat = sync_q[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_prev_q <= 1'b0;
    else             sclk_prev_q <= sclk;
  end
  assign bit_en = sclk & ~sclk_prev_q;

  // frame decode
  rx_evt_t           evt;
  mgmt_op_e          op;
  logic [DATA_W-1:0] word;

  mgmt_frame_rx #(.PRE_MIN(PRE_MIN), .FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bit_en  (bit_en),
    .bit_val (sdat),
    .cfg_port(cfg_port_i),
    .cfg_dev (cfg_dev_i),
    .evt     (evt),
    .op      (op),
    .word    (word)
  );

  // command decode
  logic rd_d, wr_d, ptr_ld, ptr_inc, addr_en;
  assign rd_d    = evt.hdr_ok && (op == OP_READ || op == OP_RDINC);
  assign ptr_inc = evt.hdr_ok && (op == OP_RDINC);
  assign wr_d    = evt.data_last && (op == OP_WRITE);
  assign ptr_ld  = evt.data_last && (op == OP_ADDR);
  assign addr_en = rd_d || wr_d;

  logic [ADDR_W-1:0] ptr;

  mgmt_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (ptr_ld),
    .load_val(word),
    .inc     (ptr_inc),
    .ptr     (ptr)
  );

  // register file port
  logic              rd_q, wr_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (addr_en) addr_d  = ptr;
    if (wr_d)    wdata_d = word;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign reg_rd_o    = rd_q;
  assign reg_wr_o    = wr_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;

  // read data return
  mgmt_tx #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (rd_d),
    .rd_issue (rd_q),
    .rd_data  (reg_rdata_i),
    .ta_first (evt.ta_first),
    .ta_last  (evt.ta_last),
    .data_bit (evt.data_bit),
    .data_last(evt.data_last),
    .drv_o    (mgmt_data_o),
    .drv_oe   (mgmt_data_oe_o)
  );

  // R4: read and write strobes never coincide
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr_o && reg_rd_o));

  // R5: a write strobe lasts one cycle
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |=> !reg_wr_o);

  // R7: the pointer sits one past the address just handed to the read
  assert_inc_after_read_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_d && op == OP_RDINC) |=> (ptr == ADDR_W'(reg_addr_o + 1'b1)));

endmodule

// File: tb/mgmt_target_bench.sv
module mgmt_target_bench;

  localparam int RDL = 2;
  localparam logic [4:0] MY_PORT = 5'h0B;
  localparam logic [4:0] MY_DEV  = 5'h1E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        mclk = 1'b0;
  logic        m_drv = 1'b1;
  logic        dut_o, dut_oe, line;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  assign line = dut_oe ? dut_o : m_drv;

  mgmt_target #(.RD_LAT(RDL)) u_mgmt_target (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_port_i    (MY_PORT),
    .cfg_dev_i     (MY_DEV),
    .mgmt_clk_i    (mclk),
    .mgmt_data_i   (line),
    .mgmt_data_o   (dut_o),
    .mgmt_data_oe_o(dut_oe),
    .reg_addr_o    (reg_addr),
    .reg_wr_o      (reg_wr),
    .reg_wdata_o   (reg_wdata),
    .reg_rd_o      (reg_rd),
    .reg_rdata_i   (reg_rdata)
  );

  // register file model with fixed read latency; filler word elsewhere
  logic [15:0] mem [logic [15:0]];
  logic [15:0] rpipe [RDL];

  function automatic logic [15:0] mem_val(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 16'hC35A;
  endfunction

  always @(posedge clk) begin
    rpipe[0] <= reg_rd ? mem_val(reg_addr) : 16'hBAD0;
    for (int i = 1; i < RDL; i++) rpipe[i] <= rpipe[i-1];
  end
  assign reg_rdata = rpipe[RDL-1];

  // scoreboard
  logic [31:0] wq[$];
  logic [15:0] aq[$];
  logic [15:0] rq[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] bptr = 16'h0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: strobes popped against driver expectations
  always @(negedge clk) begin : monitor
    logic [31:0] ew;
    logic [15:0] ea;
    if (rst_n) begin
      if (reg_wr) begin
        if (wq.size() == 0) chk(1'b0, "R1 R3 R4 unexpected write strobe", {reg_addr, reg_wdata}, 32'h0);
        else begin
          ew = wq.pop_front();
          chk({reg_addr, reg_wdata} == ew, "R5 write address and data", {reg_addr, reg_wdata}, ew);
          mem[reg_addr] = reg_wdata;
        end
      end
      if (reg_rd) begin
        if (aq.size() == 0) chk(1'b0, "R1 R3 R4 unexpected read strobe", {16'h0, reg_addr}, 32'h0);
        else begin
          ea = aq.pop_front();
          chk(reg_addr == ea, "R6 R7 read address", {16'h0, reg_addr}, {16'h0, ea});
        end
      end
    end
  end

  // one bus-clock period; samples line just before the rising edge
  task automatic mbit(input logic b, output logic smp, output logic oe_smp);
    @(negedge clk);
    m_drv = b;
    repeat (7) @(negedge clk);
    smp    = line;
    oe_smp = dut_oe;
    mclk   = 1'b1;
    repeat (8) @(negedge clk);
    mclk = 1'b0;
  endtask

  task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] port,
                       input logic [4:0] dev, input logic [15:0] data, input int pre_len);
    bit          resp, drove;
    logic        s, o;
    logic [15:0] got, exp_w;
    resp  = (st == 2'b00) && (pre_len >= 32) && (port == MY_PORT) && (dev == MY_DEV);
    drove = 1'b0;
    got   = '0;
    exp_w = '0;
    if (resp) begin
      case (op)
        2'b00: bptr = data;
        2'b01: wq.push_back({bptr, data});
        default: begin
          aq.push_back(bptr);
          rq.push_back(mem_val(bptr));
          if (op == 2'b10) bptr = bptr + 16'h1;
        end
      endcase
    end
    for (int i = 0; i < pre_len; i++) mbit(1'b1, s, o);
    mbit(st[1], s, o); mbit(st[0], s, o);
    mbit(op[1], s, o); mbit(op[0], s, o);
    for (int i = 4; i >= 0; i--) mbit(port[i], s, o);
    for (int i = 4; i >= 0; i--) mbit(dev[i], s, o);
    if (op[1]) begin
      mbit(1'b1, s, o);
      if (resp) chk(o == 1'b0, "R8 no drive in first turnaround", {31'h0, o}, 32'h0);
      drove |= o;
      mbit(1'b1, s, o);
      if (resp) chk(o && !s, "R6 turnaround zero driven", {30'h0, o, s}, 32'h2);
      drove |= o;
      for (int i = 15; i >= 0; i--) begin
        mbit(1'b1, s, o);
        got[i] = s;
        drove |= o;
      end
      if (resp) begin
        chk(dut_oe == 1'b0, "R8 release after last bit", {31'h0, dut_oe}, 32'h0);
        exp_w = rq.pop_front();
        chk(got == exp_w, "R6 R9 read data", {16'h0, got}, {16'h0, exp_w});
      end else begin
        chk(!drove && !dut_oe, "R1 R2 R3 no drive on ignored read", {31'h0, drove}, 32'h0);
      end
    end else begin
      mbit(1'b1, s, o); mbit(1'b0, s, o);
      for (int i = 15; i >= 0; i--) begin
        mbit(data[i], s, o);
        drove |= o;
      end
      chk(!drove, "R8 no drive in non-read frame", {31'h0, drove}, 32'h0);
    end
    m_drv = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R10: idle state after reset
    chk(!dut_oe && !reg_wr && !reg_rd, "R10 reset outputs", {29'h0, dut_oe, reg_wr, reg_rd}, 32'h0);
    // R10: pointer starts at zero
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    // R4 R5 R6: address, write, read back
    frame(2'b00, 2'b00, MY_PORT, MY_DEV, 16'h1234, 32);
    frame(2'b00, 2'b01, MY_PORT, MY_DEV, 16'hBEEF, 32);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    // R7: incrementing reads then a plain read
    frame(2'b00, 2'b10, MY_PORT, MY_DEV, 16'h0, 32);
    frame(2'b00, 2'b10, MY_PORT, MY_DEV, 16'h0, 32);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    // R7: wrap at the top of the address space
    frame(2'b00, 2'b00, MY_PORT, MY_DEV, 16'hFFFF, 32);
    frame(2'b00, 2'b01, MY_PORT, MY_DEV, 16'h0F0F, 32);
    frame(2'b00, 2'b10, MY_PORT, MY_DEV, 16'h0, 32);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    // R3: wrong port or device is ignored
    frame(2'b00, 2'b00, MY_PORT ^ 5'h01, MY_DEV, 16'h5555, 32);
    frame(2'b00, 2'b01, MY_PORT, MY_DEV ^ 5'h10, 16'hAAAA, 32);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV ^ 5'h01, 16'h0, 32);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    // R1: older start code 01 is passed over
    frame(2'b01, 2'b01, MY_PORT, MY_DEV, 16'h7777, 32);
    frame(2'b01, 2'b00, MY_PORT, MY_DEV, 16'h4444, 32);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    // R2: short preamble ignored, long preamble accepted
    frame(2'b00, 2'b00, MY_PORT, MY_DEV, 16'h2222, 31);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    frame(2'b00, 2'b00, MY_PORT, MY_DEV, 16'h2222, 40);
    frame(2'b00, 2'b01, MY_PORT, MY_DEV, 16'h600D, 33);
    frame(2'b00, 2'b11, MY_PORT, MY_DEV, 16'h0, 32);
    repeat (20) @(negedge clk);
    // R4 R5: every expected strobe was seen
    chk(wq.size() == 0 && aq.size() == 0, "R4 R5 all expected strobes seen",
        wq.size() + aq.size(), 32'h0);
    finish_run();
  end

endmodule